// File: doc/BRIEF.md
# Receive Block Buffer with One-Shot DMA Request

This block sits between the data lines of a block-oriented card interface and a host bus. Bytes arriving from the card are packed little-endian into 32-bit words and stored in a word buffer. The buffer holds two blocks of the largest programmable size. Each time a full block of the programmed byte length has landed, the block pulls its active-low DMA request low, once for that block. A DMA engine or processor then drains the block with 32-bit reads, either all at once or in bursts that it counts itself.

The request goes high on the first word read. It stays high until the reader has taken exactly one block's worth of words and another finished block is waiting. The card side is never allowed to overrun the buffer. Once the buffer cannot take the next byte, the card clock enable falls, and it only rises again after a whole block has been read out.

A transfer-active flag runs from a start pulse until the announced number of blocks has been read. Reading from an empty buffer returns zero and raises a sticky underflow flag.

Top module: `rx_blk_dma_ctrl`

## Requirements
- R1: Card bytes are packed little-endian: the first byte of each group of four lands in bits 7:0. A block of L bytes (1 to 2047) fills L/4+1 words (integer division). Its last partial word has zero upper bytes, and when L is a multiple of 4 the block ends with one all-zero word.
- R2: `dma_req_n` goes low once a complete block is present in the buffer, and stays high while only part of a block has arrived.
- R3: When a block has more than one word, the first word read of that block drives `dma_req_n` high in the following cycle.
- R4: After its first read, the request stays high until exactly L/4+1 words have been read. It returns low at that point only if another complete block is already buffered.
- R5: Words are read in the order they were written. Read data is registered and appears in the cycle after `host_rd_en`.
- R6: A read while `buf_level` is 0 returns zero on `host_rd_data`, leaves `buf_level` unchanged and sets the sticky `rd_underflow` flag.
- R7: The buffer never overflows. `buf_level` never exceeds 1024 words, `card_clk_en` is low whenever the next byte could need a slot the buffer lacks, and a byte offered while `card_clk_en` is low is ignored.
- R8: Once `card_clk_en` has dropped for lack of space, it stays low until a complete block has been read out, even if single words are read before then.
- R9: A `rx_start` pulse with a nonzero `rx_nblk` sets `rx_active`. The flag clears when that many blocks have been fully read.
- R10: A synchronous active-low reset empties the buffer, clears counters and flags, and leaves `dma_req_n` high and `card_clk_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_len | input | 11 | Block length in bytes, held constant while blocks are in flight |
| card_wr_en | input | 1 | Card-side byte strobe |
| card_wr_byte | input | 8 | Card-side byte |
| card_clk_en | output | 1 | Enable for the card clock; low stalls the card |
| host_rd_en | input | 1 | Host/DMA 32-bit read strobe |
| host_rd_data | output | 32 | Registered read data |
| dma_req_n | output | 1 | Active-low DMA read request |
| rx_start | input | 1 | Pulse that opens a receive transfer |
| rx_nblk | input | 8 | Number of blocks in the transfer |
| rx_active | output | 1 | Receive transfer in progress |
| rd_underflow | output | 1 | Sticky flag: a read hit an empty buffer |
| buf_level | output | 11 | Words currently held |

## Verification
The hardest state to reach from the ports is a completely full buffer with the card clock gated. To get there, the bench programs the largest block length and writes two whole blocks without any reads. It offers a stray byte while the clock is stopped, then reads single words to show the gate holds until a block is gone. The bench then drains the buffer and writes a short block, which exposes whether the stray byte was taken. The masking rule is also exercised by randomized runs that interleave partial reads with the arrival of the next block, and every read is compared with a packing and block-count model kept in the bench.

// File: rtl/rxdma_pkg.sv
// Package rxdma_pkg
// Shared constants and the word-write record passed from the byte packer
// to the word buffer. Assumes a fixed 32-bit host word.
package rxdma_pkg;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic              we;
        logic [WORD_W-1:0] data;
    } wr_word_t;
endpackage

// File: rtl/rxdma_byte_packer.sv
// Module rxdma_byte_packer
// Packs card bytes little-endian into 32-bit words, flushes a partial word
// at the end of each block and adds a zero pad word when the block length
// is a multiple of four, so every block fills blk_len/4+1 words.
// Assumes byte_en is already gated by the card clock enable and that
// blk_len is nonzero and stable while a block is arriving.
module rxdma_byte_packer
    import rxdma_pkg::*;
#(
    parameter int BLEN_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLEN_W-1:0] blk_len,
    input  logic              byte_en,
    input  logic [7:0]        byte_in,
    output wr_word_t          wr,
    output logic              blk_done,
    output logic              pad_pend,
    output logic [1:0]        slots_need
);
    logic [BLEN_W-1:0] byte_idx;
    logic [WORD_W-1:0] acc;
    logic              pad_q;
    logic [1:0]        lane;
    logic              is_last;
    logic [WORD_W-1:0] merged;

    assign lane     = byte_idx[1:0];
    assign is_last  = (byte_idx == blk_len - BLEN_W'(1));
    assign merged   = acc | (WORD_W'(byte_in) << {lane, 3'b000});
    assign pad_pend = pad_q;

    // Word slots the next accepted byte may consume (pad counted ahead).
    always_comb begin
        if (is_last && lane == 2'd3)       slots_need = 2'd2;
        else if (is_last || lane == 2'd3)  slots_need = 2'd1;
        else                               slots_need = 2'd0;
    end

    // Word write and block-complete strobe for this cycle.
    always_comb begin
        wr       = '0;
        blk_done = 1'b0;
        if (pad_q) begin
            wr.we    = 1'b1;
            blk_done = 1'b1;
        end else if (byte_en && (lane == 2'd3 || is_last)) begin
            wr.we    = 1'b1;
            wr.data  = merged;
            blk_done = is_last && (lane != 2'd3);
        end
    end

    // Byte position, partial-word accumulator and pad-pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_idx <= '0;
            acc      <= '0;
            pad_q    <= 1'b0;
        end else if (pad_q) begin
            pad_q <= 1'b0;
        end else if (byte_en) begin
            if (is_last) begin
                byte_idx <= '0;
                acc      <= '0;
                pad_q    <= (lane == 2'd3);
            end else begin
                byte_idx <= byte_idx + BLEN_W'(1);
                acc      <= (lane == 2'd3) ? '0 : merged;
            end
        end
    end

    AST_PAD_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        pad_q |-> !byte_en);  // R7
endmodule

// File: rtl/rxdma_word_buf.sv
// Module rxdma_word_buf
// Circular word store of 2**AW entries with a registered read port.
// A read of an empty store returns zero and sets a sticky underflow flag.
// Assumes the writer never writes into a full store.
module rxdma_word_buf
    import rxdma_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_word_t          wr,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_ok,
    output logic [AW:0]       level,
    output logic              underflow
);
    localparam int DEPTH = 2 ** AW;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;

    assign rd_ok = rd_en && (level != '0);

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr.we) mem[wptr] <= wr.data;
    end

    // Pointers, fill level, read data and the underflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr      <= '0;
            rptr      <= '0;
            level     <= '0;
            rd_data   <= '0;
            underflow <= 1'b0;
        end else begin
            if (wr.we) wptr <= wptr + AW'(1);
            if (rd_ok) rptr <= rptr + AW'(1);
            level <= level + (AW+1)'(wr.we) - (AW+1)'(rd_ok);
            if (rd_ok)      rd_data <= mem[rptr];
            else if (rd_en) rd_data <= '0;
            if (rd_en && level == '0) underflow <= 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.we && !rd_ok) |-> (level != (AW+1)'(DEPTH)));  // R7
    AST_UFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && level == '0) |=> (rd_data == '0 && underflow));  // R6
    AST_UFLOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && level == '0 && !wr.we) |=> (level == '0));  // R6
endmodule

// File: rtl/rxdma_req_ctrl.sv
// Module rxdma_req_ctrl
// Counts words read per block, tracks complete blocks held, drives the
// one-shot active-low DMA request, gates the card clock when the buffer
// cannot take the next byte, and keeps the transfer-active flag.
// Assumes blk_len is stable while blocks are buffered.
module rxdma_req_ctrl #(
    parameter int BLEN_W = 11,
    parameter int AW     = 10,
    parameter int NBLK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLEN_W-1:0] blk_len,
    input  logic              blk_wr_done,
    input  logic              rd_ok,
    input  logic [AW:0]       level,
    input  logic [1:0]        slots_need,
    input  logic              pad_pend,
    input  logic              rx_start,
    input  logic [NBLK_W-1:0] rx_nblk,
    output logic              dma_req_n,
    output logic              card_clk_en,
    output logic              rx_active
);
    localparam int DEPTH = 2 ** AW;
    localparam int LW    = AW + 2;

    logic [BLEN_W-1:0] words_per;
    logic [BLEN_W-1:0] rd_cnt, rd_cnt_nxt;
    logic [AW:0]       avail, avail_nxt;
    logic              blk_rd_done;
    logic              stall_q;
    logic              space_ok;
    logic [NBLK_W-1:0] blk_left;

    assign words_per   = (blk_len >> 2) + BLEN_W'(1);
    assign blk_rd_done = rd_ok && (rd_cnt == words_per - BLEN_W'(1));
    assign rd_cnt_nxt  = blk_rd_done ? '0 : rd_cnt + BLEN_W'(rd_ok);
    assign avail_nxt   = avail + (AW+1)'(blk_wr_done)
                       - (AW+1)'(blk_rd_done && avail != '0);
    assign space_ok    = (level != (AW+1)'(DEPTH)) &&
                         (LW'(level) + LW'(slots_need) <= LW'(DEPTH));
    assign card_clk_en = space_ok && !stall_q && !pad_pend;

    // Per-block read count, complete-block count and registered request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt    <= '0;
            avail     <= '0;
            dma_req_n <= 1'b1;
        end else begin
            rd_cnt    <= rd_cnt_nxt;
            avail     <= avail_nxt;
            dma_req_n <= !((avail_nxt != '0) && (rd_cnt_nxt == '0));
        end
    end

    // Card clock stall: latched when full, released by a whole-block read.
    always_ff @(posedge clk) begin
        if (!rst_n)           stall_q <= 1'b0;
        else if (blk_rd_done) stall_q <= 1'b0;
        else if (!space_ok)   stall_q <= 1'b1;
    end

    // Transfer-active flag and remaining-block count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_active <= 1'b0;
            blk_left  <= '0;
        end else if (rx_start) begin
            rx_active <= (rx_nblk != '0);
            blk_left  <= rx_nblk;
        end else if (blk_rd_done && rx_active) begin
            blk_left <= blk_left - NBLK_W'(1);
            if (blk_left == NBLK_W'(1)) rx_active <= 1'b0;
        end
    end

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req_n && rd_ok && words_per != BLEN_W'(1)) |=> dma_req_n);  // R3
    AST_REQ_HAS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_req_n |-> (LW'(level) >= LW'(words_per)));  // R2
    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_clk_en && !pad_pend && !rd_ok) |=> !card_clk_en);  // R8
endmodule

// File: rtl/rx_blk_dma_ctrl.sv
// Module rx_blk_dma_ctrl
// Top of the receive block buffer: byte packer, word buffer and request /
// clock-gate controller. Card bytes are accepted only while card_clk_en
// is high. Buffer depth is two blocks of the largest length.
module rx_blk_dma_ctrl
    import rxdma_pkg::*;
#(
    parameter int BLEN_W = 11,
    parameter int NBLK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLEN_W-1:0] blk_len,
    input  logic              card_wr_en,
    input  logic [7:0]        card_wr_byte,
    output logic              card_clk_en,
    input  logic              host_rd_en,
    output logic [31:0]       host_rd_data,
    output logic              dma_req_n,
    input  logic              rx_start,
    input  logic [NBLK_W-1:0] rx_nblk,
    output logic              rx_active,
    output logic              rd_underflow,
    output logic [BLEN_W-1:0] buf_level
);
    localparam int AW = BLEN_W - 1;

    wr_word_t    wr;
    logic        blk_done;
    logic        pad_pend;
    logic [1:0]  slots_need;
    logic        rd_ok;
    logic        byte_en;
    logic [AW:0] level;

    assign byte_en   = card_wr_en && card_clk_en;
    assign buf_level = level;

    rxdma_byte_packer #(.BLEN_W(BLEN_W)) packer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_len    (blk_len),
        .byte_en    (byte_en),
        .byte_in    (card_wr_byte),
        .wr         (wr),
        .blk_done   (blk_done),
        .pad_pend   (pad_pend),
        .slots_need (slots_need)
    );

    rxdma_word_buf #(.AW(AW)) buf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr),
        .rd_en     (host_rd_en),
        .rd_data   (host_rd_data),
        .rd_ok     (rd_ok),
        .level     (level),
        .underflow (rd_underflow)
    );

    rxdma_req_ctrl #(.BLEN_W(BLEN_W), .AW(AW), .NBLK_W(NBLK_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .blk_len     (blk_len),
        .blk_wr_done (blk_done),
        .rd_ok       (rd_ok),
        .level       (level),
        .slots_need  (slots_need),
        .pad_pend    (pad_pend),
        .rx_start    (rx_start),
        .rx_nblk     (rx_nblk),
        .dma_req_n   (dma_req_n),
        .card_clk_en (card_clk_en),
        .rx_active   (rx_active)
    );
endmodule

// File: tb/rx_blk_dma_ctrl_tb_top.sv
`timescale 1ns/1ps
module rx_blk_dma_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] blk_len = 11'd1;
    logic        card_wr_en = 1'b0;
    logic [7:0]  card_wr_byte = 8'd0;
    logic        card_clk_en;
    logic        host_rd_en = 1'b0;
    logic [31:0] host_rd_data;
    logic        dma_req_n;
    logic        rx_start = 1'b0;
    logic [7:0]  rx_nblk = 8'd0;
    logic        rx_active;
    logic        rd_underflow;
    logic [10:0] buf_level;

    always #10 clk = ~clk;

    rx_blk_dma_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .blk_len(blk_len),
        .card_wr_en(card_wr_en), .card_wr_byte(card_wr_byte),
        .card_clk_en(card_clk_en), .host_rd_en(host_rd_en),
        .host_rd_data(host_rd_data), .dma_req_n(dma_req_n),
        .rx_start(rx_start), .rx_nblk(rx_nblk), .rx_active(rx_active),
        .rd_underflow(rd_underflow), .buf_level(buf_level)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [31:0] exp_q[$];
    int          avail = 0;
    int          rdc = 0;
    int          curlen = 1;
    int          midx = 0;
    logic [31:0] macc = 32'd0;

    function automatic int wpb(int len);
        return len / 4 + 1;
    endfunction

    function automatic logic exp_req();
        return !(avail > 0 && rdc == 0);
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_req(string tag);
        chk(dma_req_n == exp_req(), tag, 32'(dma_req_n), 32'(exp_req()));
    endtask

    task automatic set_len(int l);
        blk_len = 11'(l);
        curlen  = l;
        @(negedge clk);
    endtask

    task automatic put_byte(logic [7:0] b);
        int lane;
        while (!card_clk_en) @(negedge clk);
        card_wr_en   = 1'b1;
        card_wr_byte = b;
        @(negedge clk);
        card_wr_en = 1'b0;
        lane = midx % 4;
        macc = macc | (32'(b) << (8 * lane));
        if (midx == curlen - 1) begin
            exp_q.push_back(macc);
            macc = 32'd0;
            if (curlen % 4 == 0) exp_q.push_back(32'd0);
            avail++;
            midx = 0;
        end else begin
            if (lane == 3) begin
                exp_q.push_back(macc);
                macc = 32'd0;
            end
            midx++;
        end
    endtask

    task automatic write_block();
        for (int i = 0; i < curlen; i++) put_byte(8'($urandom));
        @(negedge clk);
    endtask

    task automatic rd_word(string tag, bit do_chk);
        logic [31:0] e;
        host_rd_en = 1'b1;
        @(negedge clk);
        host_rd_en = 1'b0;
        e = exp_q.pop_front();
        rdc++;
        if (rdc == wpb(curlen)) begin
            rdc = 0;
            avail--;
        end
        if (do_chk) begin
            chk(host_rd_data == e, tag, host_rd_data, e);
            chk_req(tag);
        end else if (host_rd_data != e) begin
            chk(1'b0, tag, host_rd_data, e);
        end
    endtask

    task automatic start_rx(int n);
        rx_nblk  = 8'(n);
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        chk(rx_active == (n != 0), "R9 start", 32'(rx_active), 32'(n != 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(dma_req_n == 1'b1, "R10 req", 32'(dma_req_n), 32'd1);
        chk(buf_level == 11'd0, "R10 level", 32'(buf_level), 32'd0);
        chk(card_clk_en == 1'b1, "R10 clk_en", 32'(card_clk_en), 32'd1);
        chk(rx_active == 1'b0, "R10 active", 32'(rx_active), 32'd0);
        chk(rd_underflow == 1'b0, "R10 uflow", 32'(rd_underflow), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R3/R5: five-byte block, directed bytes
        set_len(5);
        put_byte(8'h01); put_byte(8'h02); put_byte(8'h03); put_byte(8'h04);
        chk(dma_req_n == 1'b1, "R2 partial block", 32'(dma_req_n), 32'd1);
        put_byte(8'h05);
        chk(dma_req_n == 1'b0, "R2 block complete", 32'(dma_req_n), 32'd0);
        chk(buf_level == 11'd2, "R1 words per block", 32'(buf_level), 32'd2);
        rd_word("R1 R5 first word", 1'b1);
        chk(dma_req_n == 1'b1, "R3 drop on first read", 32'(dma_req_n), 32'd1);
        rd_word("R1 partial word", 1'b1);

        // R1: length multiple of 4 adds a zero word
        set_len(8);
        write_block();
        chk(buf_level == 11'd3, "R1 pad word count", 32'(buf_level), 32'd3);
        chk(dma_req_n == 1'b0, "R2 padded block", 32'(dma_req_n), 32'd0);
        for (int i = 0; i < 3; i++) rd_word("R1 R5 padded block", 1'b1);

        // R6: read of empty buffer
        host_rd_en = 1'b1;
        @(negedge clk);
        host_rd_en = 1'b0;
        chk(host_rd_data == 32'd0, "R6 data", host_rd_data, 32'd0);
        chk(rd_underflow == 1'b1, "R6 flag", 32'(rd_underflow), 32'd1);
        chk(buf_level == 11'd0, "R6 level", 32'(buf_level), 32'd0);

        // R4/R9: two queued blocks, request re-armed only after a full block
        set_len(6);
        start_rx(2);
        write_block();
        write_block();
        chk_req("R2 two blocks");
        rd_word("R3 first of two", 1'b1);
        chk(dma_req_n == 1'b1, "R4 masked mid-block", 32'(dma_req_n), 32'd1);
        rd_word("R4 rearm next block", 1'b1);
        chk(dma_req_n == 1'b0, "R4 rearmed", 32'(dma_req_n), 32'd0);
        chk(rx_active == 1'b1, "R9 still active", 32'(rx_active), 32'd1);
        rd_word("R4 second block", 1'b1);
        rd_word("R4 drained", 1'b1);
        chk(rx_active == 1'b0, "R9 cleared", 32'(rx_active), 32'd0);

        // R7/R8: fill with two maximum blocks, no reads
        set_len(2047);
        write_block();
        write_block();
        chk(card_clk_en == 1'b0, "R7 gated when full", 32'(card_clk_en), 32'd0);
        chk(buf_level == 11'd1024, "R7 level full", 32'(buf_level), 32'd1024);
        card_wr_en = 1'b1;
        card_wr_byte = 8'hAA;
        @(negedge clk);
        card_wr_en = 1'b0;
        chk(buf_level == 11'd1024, "R7 byte ignored", 32'(buf_level), 32'd1024);
        rd_word("R8 single read", 1'b1);
        chk(card_clk_en == 1'b0, "R8 held after one read", 32'(card_clk_en), 32'd0);
        for (int i = 0; i < 510; i++) rd_word("R5 drain", 1'b0);
        chk(card_clk_en == 1'b0, "R8 held before block end", 32'(card_clk_en), 32'd0);
        rd_word("R4 full block read", 1'b1);
        chk(card_clk_en == 1'b1, "R8 released", 32'(card_clk_en), 32'd1);
        for (int i = 0; i < 512; i++) rd_word("R5 drain second", 1'b0);
        chk(buf_level == 11'd0, "R5 drained", 32'(buf_level), 32'd0);
        set_len(3);
        write_block();
        chk_req("R7 ignored byte not stored");
        rd_word("R7 ignored byte not stored", 1'b1);

        // Random lengths with partial reads interleaved with the next block
        for (int it = 0; it < 40; it++) begin
            int k;
            set_len(1 + int'($urandom % 48));
            write_block();
            chk_req("R2 random block");
            k = int'($urandom % wpb(curlen));
            for (int i = 0; i < k; i++) rd_word("R3 R5 random partial", 1'b1);
            write_block();
            chk_req("R4 random second block");
            chk(32'(buf_level) == 32'(exp_q.size()), "R1 random level",
                32'(buf_level), 32'(exp_q.size()));
            while (exp_q.size() > 0) rd_word("R4 R5 random drain", 1'b1);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule